// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Per-Entry Page Size

This block is a small, fully associative address translation buffer. Each entry covers two neighbouring virtual pages, an even one and an odd one, and maps each of them to its own physical frame with its own valid and dirty bits. Every entry stores its own size mask. The mask sets how many address bits take part in the tag compare, which bit picks the even or odd frame, and how many low bits pass through as the page offset. The smallest pair covers 8 KiB, made of two 4 KiB pages.

Software-style register images load an entry and read it back. On a write, four 32-bit images (a high word with the virtual page and address-space tag, a size mask, and one low word per frame) are written to a chosen index. They become visible on the following clock edge. The read port rebuilds the same four images from any index without delay. The lookup port is combinational. It takes a virtual address, the current address-space tag and a store flag, and returns the match result, the faults, the physical address and the write permission. Every port is plain: a load is taken on any cycle that asserts it, and a lookup or read gives its result in the same cycle. No port ever stalls, so the block has no back-pressure and needs no valid/ready handshake.

Top module: `pair_tlb`

## Requirements
- R1: Reset clears every stored field to zero. After reset the read port returns all-zero images at every index. A lookup with address-space tag 0 and an address below 8 KiB then matches entry 0 and reports an invalid fault.
- R2: When `wr_en` is high at a rising clock edge, entry `wr_idx` takes the following values from that edge on. The page number is `wr_hi` with bits 12:0 cleared. The tag is `wr_hi[7:0]`. The mask is `wr_mask` unchanged. The global bit is `wr_lo0[0] & wr_lo1[0]`. From each low image, the valid bit is bit 1, the dirty bit is bit 2, the 3-bit attribute is bits 5:3 and the frame number is bits 31:6.
- R3: The read port returns the following images for entry `rd_idx` in the same cycle. `rd_hi` is the page number ORed with the tag. `rd_mask` is the stored mask. Each `rd_lo` holds the frame number in bits 31:6, the attribute in bits 5:3, dirty in bit 2, valid in bit 1 and the shared global bit in bit 0.
- R4: Let the effective mask of an entry be its stored mask ORed with 0x1FFF. The entry matches when `lk_va` with its effective-mask bits cleared equals the stored page number, and the entry is either global or has a tag equal to `lk_asid`. `lk_hit` is high exactly when some entry matches.
- R5: The highest set bit of the effective mask picks the frame. If that bit of `lk_va` is 0, the even frame is used. If it is 1, the odd frame is used.
- R6: On a hit, `lk_pa` (38 bits) is the selected frame number shifted left by 12, ORed with the bits of `lk_va` below the select bit.
- R7: On a hit whose selected frame has its valid bit clear, `lk_invalid` is high for both loads and stores. In that case `lk_modified` and `lk_writable` are low.
- R8: On a hit with the selected frame valid, `lk_writable` equals that frame's dirty bit. `lk_modified` is high only for a store (`lk_write`=1) to a frame whose dirty bit is clear.
- R9: When several entries match, the entry with the lowest index supplies the result.
- R10: When no entry matches, `lk_miss` is high, `lk_pa` is zero, and `lk_invalid`, `lk_modified` and `lk_writable` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Load an entry at the next edge |
| wr_idx | input | 4 | Entry index to load |
| wr_hi | input | 32 | High image: page number and tag |
| wr_mask | input | 32 | Size mask image |
| wr_lo0 | input | 32 | Even frame low image |
| wr_lo1 | input | 32 | Odd frame low image |
| rd_idx | input | 4 | Entry index to read back |
| rd_hi | output | 32 | Rebuilt high image |
| rd_mask | output | 32 | Rebuilt mask image |
| rd_lo0 | output | 32 | Rebuilt even low image |
| rd_lo1 | output | 32 | Rebuilt odd low image |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| lk_hit | output | 1 | Some entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_pa | output | 38 | Translated physical address |
| lk_invalid | output | 1 | Selected frame not valid |
| lk_modified | output | 1 | Store to a clean frame |
| lk_writable | output | 1 | Selected frame permits stores |

## Verification
The offset assertion assumes that each effective mask is a contiguous run of ones starting at bit 0. Only then is the select bit the single top bit and the pass-through field contiguous. The bench keeps to this by loading masks only from a set of contiguous values (0, 0x6000, up to 0x1FFE000). It also clears the mask region from each random high image, so random entries can still be reached. The write-visibility property assumes the read index is held across the edge that commits a load. The bench changes inputs only at falling edges, so both indices are stable around each committing edge.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  localparam int REG_W       = 32;
  localparam int ASID_W      = 8;
  localparam int ATTR_W      = 3;
  localparam int PFN_LSB     = 6;
  localparam int PFN_W       = REG_W - PFN_LSB;
  localparam int FRAME_SHIFT = 12;
  localparam int PA_W        = PFN_W + FRAME_SHIFT;
  localparam int VPN_LSB     = 13;
  localparam logic [REG_W-1:0] MIN_MASK = REG_W'((1 << VPN_LSB) - 1);

  typedef struct packed {
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
    logic              dirty;
    logic              valid;
  } half_t;

  typedef struct packed {
    logic [REG_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [REG_W-1:0]  mask;
    logic              glob;
    half_t             even;
    half_t             odd;
  } entry_t;

  function automatic half_t split_lo(input logic [REG_W-1:0] lo);
    half_t h;
    h.pfn   = lo[REG_W-1:PFN_LSB];
    h.attr  = lo[PFN_LSB-1:3];
    h.dirty = lo[2];
    h.valid = lo[1];
    return h;
  endfunction

  function automatic logic [REG_W-1:0] join_lo(input half_t h, input logic g);
    return {h.pfn, h.attr, h.dirty, h.valid, g};
  endfunction
endpackage

// File: rtl/pair_tlb_entry.sv
module pair_tlb_entry
  import pair_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [REG_W-1:0]  hi_img,
  input  logic [REG_W-1:0]  mask_img,
  input  logic [REG_W-1:0]  lo0_img,
  input  logic [REG_W-1:0]  lo1_img,
  input  logic [REG_W-1:0]  va,
  input  logic [ASID_W-1:0] asid,
  output entry_t            ent,
  output logic              match
);
  logic [REG_W-1:0] eff_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent <= '0;
    end else if (load) begin
      ent.vpn  <= hi_img & ~MIN_MASK;
      ent.asid <= hi_img[ASID_W-1:0];
      ent.mask <= mask_img;
      ent.glob <= lo0_img[0] & lo1_img[0];
      ent.even <= split_lo(lo0_img);
      ent.odd  <= split_lo(lo1_img);
    end
  end

  always_comb begin
    eff_mask = ent.mask | MIN_MASK;
    match    = ((va & ~eff_mask) == ent.vpn) && (ent.glob || (ent.asid == asid));
  end
endmodule

// File: rtl/pair_tlb_pick.sv
module pair_tlb_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/pair_tlb_xlate.sv
module pair_tlb_xlate
  import pair_tlb_pkg::*;
(
  input  entry_t           ent,
  input  logic             hit,
  input  logic [REG_W-1:0] va,
  input  logic             write,
  output logic [PA_W-1:0]  pa,
  output logic             invalid,
  output logic             modified,
  output logic             writable
);
  logic [REG_W-1:0] eff_mask;
  logic [REG_W-1:0] sel_bit;
  logic [REG_W-1:0] offset;
  logic             odd;
  half_t            half;

  always_comb begin
    eff_mask = ent.mask | MIN_MASK;
    sel_bit  = eff_mask & ~(eff_mask >> 1);
    odd      = |(va & sel_bit);
    half     = odd ? ent.odd : ent.even;
    offset   = va & (eff_mask >> 1);
    pa       = hit ? ({half.pfn, {FRAME_SHIFT{1'b0}}} | PA_W'(offset)) : '0;
    invalid  = hit & ~half.valid;
    modified = hit & half.valid & write & ~half.dirty;
    writable = hit & half.valid & half.dirty;
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_hi,
  input  logic [REG_W-1:0]  wr_mask,
  input  logic [REG_W-1:0]  wr_lo0,
  input  logic [REG_W-1:0]  wr_lo1,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [REG_W-1:0]  rd_hi,
  output logic [REG_W-1:0]  rd_mask,
  output logic [REG_W-1:0]  rd_lo0,
  output logic [REG_W-1:0]  rd_lo1,
  input  logic [REG_W-1:0]  lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_invalid,
  output logic              lk_modified,
  output logic              lk_writable
);
  entry_t                 ents [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] match_v;
  logic [NUM_ENTRIES-1:0] grant_v;
  logic                   any_match;
  entry_t                 sel_ent;
  entry_t                 rd_ent;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    pair_tlb_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_en && (wr_idx == IDX_W'(i))),
      .hi_img   (wr_hi),
      .mask_img (wr_mask),
      .lo0_img  (wr_lo0),
      .lo1_img  (wr_lo1),
      .va       (lk_va),
      .asid     (lk_asid),
      .ent      (ents[i]),
      .match    (match_v[i])
    );
  end

  pair_tlb_pick #(.N(NUM_ENTRIES)) u_pick (
    .req   (match_v),
    .grant (grant_v),
    .any   (any_match)
  );

  always_comb begin
    sel_ent = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (grant_v[i]) sel_ent = ents[i];
    end
  end

  pair_tlb_xlate u_xlate (
    .ent      (sel_ent),
    .hit      (any_match),
    .va       (lk_va),
    .write    (lk_write),
    .pa       (lk_pa),
    .invalid  (lk_invalid),
    .modified (lk_modified),
    .writable (lk_writable)
  );

  assign lk_hit  = any_match;
  assign lk_miss = ~any_match;

  always_comb begin
    rd_ent  = ents[rd_idx];
    rd_hi   = rd_ent.vpn | REG_W'(rd_ent.asid);
    rd_mask = rd_ent.mask;
    rd_lo0  = join_lo(rd_ent.even, rd_ent.glob);
    rd_lo1  = join_lo(rd_ent.odd, rd_ent.glob);
  end
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter int IDX_W = 4,
  parameter int PA_W  = 38
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [31:0]      wr_hi,
  input logic [31:0]      wr_mask,
  input logic [IDX_W-1:0] rd_idx,
  input logic [31:0]      rd_hi,
  input logic [31:0]      rd_mask,
  input logic [31:0]      lk_va,
  input logic             lk_write,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic [PA_W-1:0]  lk_pa,
  input logic             lk_invalid,
  input logic             lk_modified,
  input logic             lk_writable
);
  a_r10_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_pa == '0 && !lk_invalid && !lk_modified && !lk_writable));

  a_r4_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit != lk_miss);

  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

  a_r7_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_invalid, lk_modified, lk_writable}));

  a_r8_modified_store: assert property (@(posedge clk) disable iff (!rst_n)
    lk_modified |-> lk_write);

  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_idx != $past(wr_idx)) ||
               (rd_hi == ($past(wr_hi) & 32'hFFFF_E0FF) && rd_mask == $past(wr_mask))));
endmodule

bind pair_tlb pair_tlb_chk #(.IDX_W(IDX_W), .PA_W(pair_tlb_pkg::PA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_hi       (wr_hi),
  .wr_mask     (wr_mask),
  .rd_idx      (rd_idx),
  .rd_hi       (rd_hi),
  .rd_mask     (rd_mask),
  .lk_va       (lk_va),
  .lk_write    (lk_write),
  .lk_hit      (lk_hit),
  .lk_miss     (lk_miss),
  .lk_pa       (lk_pa),
  .lk_invalid  (lk_invalid),
  .lk_modified (lk_modified),
  .lk_writable (lk_writable)
);

// File: tb/pair_tlb_bench.sv
module pair_tlb_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_hi = '0, wr_mask = '0, wr_lo0 = '0, wr_lo1 = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_hi, rd_mask, rd_lo0, rd_lo1;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_write = 1'b0;
  logic        lk_hit, lk_miss, lk_invalid, lk_modified, lk_writable;
  logic [37:0] lk_pa;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string phase = "R1";

  logic [31:0] m_vpn  [N];
  logic [31:0] m_mask [N];
  logic [7:0]  m_asid [N];
  bit          m_g    [N];
  logic [31:0] m_lo0  [N];
  logic [31:0] m_lo1  [N];

  logic [31:0] mask_set [7] = '{32'h0, 32'h6000, 32'h1E000, 32'h7E000,
                               32'h1FE000, 32'h7FE000, 32'h1FFE000};

  always #2.5 clk = ~clk;

  pair_tlb u_pair_tlb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_mask(wr_mask), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
    .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_mask(rd_mask), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1),
    .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_invalid(lk_invalid),
    .lk_modified(lk_modified), .lk_writable(lk_writable)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (phase %s) %s actual=%0h expected=%0h", req, phase, what, act, exp);
    end
  endtask

  task automatic model_write();
    m_vpn[wr_idx]  = wr_hi & 32'hFFFF_E000;
    m_asid[wr_idx] = wr_hi[7:0];
    m_mask[wr_idx] = wr_mask;
    m_g[wr_idx]    = wr_lo0[0] & wr_lo1[0];
    m_lo0[wr_idx]  = wr_lo0;
    m_lo1[wr_idx]  = wr_lo1;
  endtask

  task automatic compare_all();
    bit          e_hit = 0;
    logic [37:0] e_pa = '0;
    bit          e_inv = 0, e_mod = 0, e_wr = 0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] eff;
      eff = m_mask[i] | 32'h1FFF;
      if (!e_hit && ((lk_va & ~eff) == m_vpn[i]) && (m_g[i] || m_asid[i] == lk_asid)) begin
        int top;
        logic [31:0] lo;
        top = 0;
        for (int b = 31; b >= 0; b--) if (eff[b] && top == 0) top = b;
        lo = lk_va[top] ? m_lo1[i] : m_lo0[i];
        e_hit = 1;
        e_pa  = ({12'b0, lo[31:6]} << 12) | {6'b0, lk_va & ((32'd1 << top) - 1)};
        e_inv = !lo[1];
        e_wr  = lo[1] && lo[2];
        e_mod = lo[1] && !lo[2] && lk_write;
      end
    end
    chk("R4", "lk_hit", 64'(lk_hit), 64'(e_hit));
    chk("R10", "lk_miss", 64'(lk_miss), 64'(!e_hit));
    chk("R6", "lk_pa", 64'(lk_pa), 64'(e_pa));
    chk("R7", "lk_invalid", 64'(lk_invalid), 64'(e_inv));
    chk("R8", "lk_modified", 64'(lk_modified), 64'(e_mod));
    chk("R8", "lk_writable", 64'(lk_writable), 64'(e_wr));
    chk("R3", "rd_hi", 64'(rd_hi), 64'(m_vpn[rd_idx] | {24'b0, m_asid[rd_idx]}));
    chk("R3", "rd_mask", 64'(rd_mask), 64'(m_mask[rd_idx]));
    chk("R3", "rd_lo0", 64'(rd_lo0), 64'({m_lo0[rd_idx][31:1], m_g[rd_idx]}));
    chk("R3", "rd_lo1", 64'(rd_lo1), 64'({m_lo1[rd_idx][31:1], m_g[rd_idx]}));
  endtask

  task automatic tick();
    @(posedge clk);
    if (wr_en) model_write();
    @(negedge clk);
    compare_all();
  endtask

  task automatic load(input int idx, input logic [31:0] hi, input logic [31:0] mk,
                      input logic [31:0] l0, input logic [31:0] l1);
    wr_en = 1; wr_idx = 4'(idx); wr_hi = hi; wr_mask = mk; wr_lo0 = l0; wr_lo1 = l1;
    tick();
    wr_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input bit wr);
    lk_va = va; lk_asid = asid; lk_write = wr;
    tick();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_g[i] = 0; m_lo0[i] = '0; m_lo1[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    phase = "R1";
    lk_va = 32'h100; lk_asid = 8'h0; rd_idx = 4'd7;
    tick();
    chk("R1", "rd_hi after reset", 64'(rd_hi), 64'h0);
    chk("R1", "rd_lo1 after reset", 64'(rd_lo1), 64'h0);
    chk("R1", "lk_invalid at entry 0", 64'(lk_invalid), 64'h1);
    look(32'h100, 8'h5, 0);
    chk("R1", "lk_miss other tag", 64'(lk_miss), 64'h1);

    // R2 / R3: load image and read it back
    phase = "R2";
    rd_idx = 4'd3;
    load(3, 32'h0040_2A35, 32'h0, 32'h0004_8D1F, 32'h0015_9E12);
    chk("R2", "rd_hi page|tag", 64'(rd_hi), 64'h0040_2035);
    chk("R2", "rd_lo0 global cleared", 64'(rd_lo0), 64'h0004_8D1E);
    chk("R3", "rd_lo1", 64'(rd_lo1), 64'h0015_9E12);
    look(32'h0040_2ABC, 8'h35, 1);
    chk("R6", "even pa", 64'(lk_pa), 64'h0123_4ABC);
    chk("R8", "writable even", 64'(lk_writable), 64'h1);
    look(32'h0040_3ABC, 8'h35, 1);
    chk("R8", "store clean odd", 64'(lk_modified), 64'h1);
    look(32'h0040_3ABC, 8'h35, 0);
    chk("R8", "load clean odd", 64'(lk_modified), 64'h0);
    look(32'h0040_2ABC, 8'h36, 0);
    chk("R4", "tag mismatch", 64'(lk_miss), 64'h1);

    // R5: 16 KiB pages
    phase = "R5";
    load(5, 32'h0100_0007, 32'h6000, 32'h0000_0402, 32'h0000_0806);
    look(32'h0100_4123, 8'h07, 0);
    chk("R5", "odd frame by bit 14", 64'(lk_pa), 64'h2_0123);
    look(32'h0100_2123, 8'h07, 0);
    chk("R5", "even frame bit 13 offset", 64'(lk_pa), 64'h1_2123);

    // R9: overlapping global entries
    phase = "R9";
    load(9, 32'h0200_0000, 32'h0, 32'h0000_2643, 32'h0000_2643);
    load(8, 32'h0200_0000, 32'h0, 32'h0000_2203, 32'h0000_2203);
    look(32'h0200_0010, 8'h44, 0);
    chk("R9", "lowest index wins", 64'(lk_pa), 64'h8_8010);

    // R7: global entry with both halves invalid
    phase = "R7";
    load(10, 32'h0300_0000, 32'h0, 32'h1, 32'h1);
    look(32'h0300_0000, 8'h9, 1);
    chk("R7", "invalid on store", 64'(lk_invalid), 64'h1);
    chk("R7", "no modified", 64'(lk_modified), 64'h0);

    // Random phase, compared every cycle
    phase = "R4";
    for (int c = 0; c < 4000; c++) begin
      int unsigned r;
      int e;
      r = $urandom;
      if (r[1:0] == 0) begin
        logic [31:0] mk;
        mk = mask_set[$urandom % 7];
        wr_en = 1; wr_idx = 4'($urandom);
        wr_hi = $urandom & ~mk; wr_mask = mk;
        wr_lo0 = $urandom; wr_lo1 = $urandom;
      end else begin
        wr_en = 0;
      end
      e = int'($urandom % N);
      lk_va = (r[3:2] == 0) ? $urandom : (m_vpn[e] | ($urandom & (m_mask[e] | 32'h1FFF)));
      lk_asid = r[4] ? m_asid[e] : 8'($urandom);
      lk_write = r[5];
      rd_idx = 4'($urandom);
      tick();
    end
    wr_en = 0;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired (phase %s) actual=hung expected=done", phase);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule